// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block serves reads on a 64 MiB memory-mapped window from a serial NOR flash. A bus master presents a word offset inside the window and holds its request. The block first looks in a small line buffer. On a hit it answers at once and does not touch the flash. On a miss it runs a single-bit serial read frame on the flash pins: an optional command byte, an optional 24- or 32-bit address, optional option bytes, optional dummy clocks, and then one or more 32-bit data words. The phase settings come from a dedicated set of read-mode inputs.

The flash byte address is the extended-address nibble placed above the window offset. A miss fetches a burst of words. The burst starts at the requested word and stops at the end of the 128-byte buffer line. The master's request completes as soon as the requested word has been shifted in. The rest of the burst continues filling the buffer in the background. Software can invalidate the buffer with a flush pulse, and it must do so after any change that alters how flash data is interpreted. When the mode input selects the manual sequencer, the window accepts no requests.

Top module: `flash_read_window`

## Requirements
- R1: While reset is held, `flashCsN` is 1, `flashSclk` is 0 and `busReady` is 0.
- R2: While `manualMode` is 1, a held request gets no `busReady` and no frame starts (`flashCsN` stays 1).
- R3: A frame keeps `flashCsN` low throughout. Each bit takes two clocks, first with `flashSclk` low and then with it high. `flashMosi` changes only while `flashSclk` is low and sends each field MSB first. `flashMiso` is sampled as `flashSclk` falls. `flashSclk` is 0 whenever `flashCsN` is 1.
- R4: The fetch address is the byte address {extAddr[3:0], busWordAddr[23:0], 2'b00}. With `addrMode` equal to 3'd1 it is sent as 32 bits, with two zero bits on top. For every other value of `addrMode`, only its low 24 bits are sent. `extAddr` is part of the buffer tag.
- R5: With `optEn` set, `optCount`+1 bytes are sent after the address, taken from `optBytes` starting at bit 31.
- R6: With `dummyEn` set, `dummyM1`+1 bit times with `flashMosi` low follow the option bytes.
- R7: Phases are sent in the order command, address, option, dummy, data. The command, address, option and dummy phases are each left out when their enable is 0. The data phase is always present.
- R8: A miss fetches N words in one frame, starting at the requested word. N = min(`burstEn` ? `burstM1`+1 : 1, 32 − (word index within its 32-word line)). Each word is shifted in MSB first. `busReady` rises with the requested word on `busRdata`.
- R9: A request whose word is held in the buffer gets `busReady` one clock after it is presented, with the stored word and no frame.
- R10: A one-clock `flush` pulse invalidates every buffered word, so the next request for any word fetches it again.
- R11: A miss in the current line keeps the words already buffered for that line. A miss in a different line (a different upper offset or `extAddr`) discards the whole old line.
- R12: `busReady` is a single-clock pulse and only answers a request that was high in the clock before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Read request, held until `busReady` |
| busWordAddr | input | 24 | Word offset inside the 64 MiB window |
| busReady | output | 1 | One-clock completion pulse |
| busRdata | output | 32 | Read data, valid with `busReady` |
| manualMode | input | 1 | 1 selects the manual sequencer and disables the window |
| extAddr | input | 4 | Flash address bits above the window |
| addrMode | input | 3 | 3'd1 sends a 32-bit address; other values send 24 bits |
| cmdEn | input | 1 | Command phase enable |
| cmdByte | input | 8 | Read command byte |
| addrEn | input | 1 | Address phase enable |
| optEn | input | 1 | Option phase enable |
| optCount | input | 2 | Option byte count minus one |
| optBytes | input | 32 | Option bytes, first byte in bits 31:24 |
| dummyEn | input | 1 | Dummy phase enable |
| dummyM1 | input | 5 | Dummy bit times minus one |
| burstEn | input | 1 | Fetch a burst on a miss instead of one word |
| burstM1 | input | 5 | Burst length in words minus one |
| flush | input | 1 | Buffer invalidate pulse |
| flashCsN | output | 1 | Flash chip select, active low |
| flashSclk | output | 1 | Flash serial clock |
| flashMosi | output | 1 | Serial data to the flash |
| flashMiso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that a master keeps `busReq` high until it sees `busReady`, and then drops it before the next rising edge. They also assume that the read-mode inputs and `manualMode` change only while no frame is running. The bench meets both conditions. Its driver drops the request at the falling edge where it sees the completion. It changes settings and mode only after `flashCsN` has returned high and the request has been released. Flush pulses are issued only between requests.

// File: rtl/flashwin_pkg.sv
package flashwin_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_OPT,
    PH_DUMMY,
    PH_DATA
  } phase_e;

  // Strobes from the sequencer to the datapath, one per clock
  typedef struct packed {
    logic   startFill;   // a miss was accepted: retag line if needed
    logic   loadTx;      // reload the transmit shifter
    phase_e loadPhase;   // which phase the reload is for
    logic   shiftTx;     // advance the transmit shifter by one bit
    logic   shiftRx;     // shift flashMiso into the receive shifter
    logic   storeWord;   // a full word is in: write it to the buffer
    logic   respHit;     // answer from the buffer
    logic   respFill;    // answer with the word just received
  } winStrobes_t;

endpackage

// File: rtl/flashwin_datapath.sv
module flashwin_datapath
  import flashwin_pkg::*;
#(
  parameter int OFS_W     = 26,
  parameter int EXT_W     = 4,
  parameter int BUF_WORDS = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [OFS_W-3:0]             busWordAddr,
  input  logic [EXT_W-1:0]             extAddr,
  input  logic [2:0]                   addrMode,
  input  logic [7:0]                   cmdByte,
  input  logic [31:0]                  optBytes,
  input  logic                         flush,
  input  logic                         flashMiso,
  input  winStrobes_t                  strb,
  output logic                         hit,
  output logic [$clog2(BUF_WORDS)-1:0] reqIdx,
  output logic                         flashMosi,
  output logic [31:0]                  busRdata
);

  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam int TAG_W = EXT_W + OFS_W - 2 - IDX_W;

  logic [TAG_W-1:0]     reqTag;
  logic [TAG_W-1:0]     lineTag;
  logic [BUF_WORDS-1:0] validBits;
  logic [31:0]          bufMem [BUF_WORDS];
  logic [IDX_W-1:0]     curIdx;
  logic [31:0]          txShift;
  logic [31:0]          txLoad;
  logic [31:0]          rxShift;
  logic [31:0]          rxNext;
  logic [31:0]          wideAddr;
  logic [31:0]          addrWord;

  assign reqIdx = busWordAddr[IDX_W-1:0];
  assign reqTag = {extAddr, busWordAddr[OFS_W-3:IDX_W]};
  assign hit    = (lineTag == reqTag) && validBits[reqIdx];

  // Flash byte address: extended nibble above the window offset
  assign wideAddr = 32'({extAddr, busWordAddr, 2'b00});
  assign addrWord = (addrMode == 3'd1) ? wideAddr : {wideAddr[23:0], 8'h00};

  always_comb begin
    unique case (strb.loadPhase)
      PH_CMD:  txLoad = {cmdByte, 24'h000000};
      PH_ADDR: txLoad = addrWord;
      PH_OPT:  txLoad = optBytes;
      default: txLoad = 32'h0;
    endcase
  end

  assign flashMosi = txShift[31];
  assign rxNext    = {rxShift[30:0], flashMiso};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.loadTx)       txShift <= txLoad;
      else if (strb.shiftTx) txShift <= {txShift[30:0], 1'b0};
      if (strb.shiftRx)      rxShift <= rxNext;
    end
  end

  // Line tag and per-word valid bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineTag   <= '0;
      validBits <= '0;
      curIdx    <= '0;
    end else begin
      if (flush) validBits <= '0;
      if (strb.startFill) begin
        curIdx  <= reqIdx;
        lineTag <= reqTag;
        if (lineTag != reqTag) validBits <= '0;
      end
      if (strb.storeWord) begin
        validBits[curIdx] <= 1'b1;
        curIdx            <= curIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeWord) bufMem[curIdx] <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busRdata <= '0;
    else if (strb.respHit)  busRdata <= bufMem[reqIdx];
    else if (strb.respFill) busRdata <= rxNext;
  end

endmodule

// File: rtl/flashwin_ctrl.sv
module flashwin_ctrl
  import flashwin_pkg::*;
#(
  parameter int BUF_WORDS = 32,
  parameter int BURST_W   = 5,
  parameter int DUMMY_W   = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busReq,
  input  logic                         manualMode,
  input  logic                         hit,
  input  logic [$clog2(BUF_WORDS)-1:0] reqIdx,
  input  logic                         cmdEn,
  input  logic                         addrEn,
  input  logic                         optEn,
  input  logic                         dummyEn,
  input  logic [2:0]                   addrMode,
  input  logic [1:0]                   optCount,
  input  logic [DUMMY_W-1:0]           dummyM1,
  input  logic                         burstEn,
  input  logic [BURST_W-1:0]           burstM1,
  output winStrobes_t                  strb,
  output logic                         busReady,
  output logic                         flashCsN,
  output logic                         flashSclk
);

  localparam int WL_W  = $clog2(BUF_WORDS + 1);
  localparam int CNT_W = (DUMMY_W > 5) ? DUMMY_W : 5;

  phase_e           ph;
  phase_e           nextPh;
  logic             half;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lenM1;
  logic [WL_W-1:0]  wordsLeft;
  logic [WL_W-1:0]  fillWords;
  logic             firstWord;
  logic             accept;
  logic             headEnd;
  logic             dataBitEnd;
  logic [15:0]      room16;
  logic [15:0]      burst16;

  // Next enabled phase after the current one; data always closes a frame
  always_comb begin
    nextPh = PH_DATA;
    if (ph == PH_IDLE && cmdEn)
      nextPh = PH_CMD;
    else if ((ph inside {PH_IDLE, PH_CMD}) && addrEn)
      nextPh = PH_ADDR;
    else if ((ph inside {PH_IDLE, PH_CMD, PH_ADDR}) && optEn)
      nextPh = PH_OPT;
    else if ((ph inside {PH_IDLE, PH_CMD, PH_ADDR, PH_OPT}) && dummyEn)
      nextPh = PH_DUMMY;
  end

  always_comb begin
    unique case (ph)
      PH_CMD:   lenM1 = CNT_W'(7);
      PH_ADDR:  lenM1 = (addrMode == 3'd1) ? CNT_W'(31) : CNT_W'(23);
      PH_OPT:   lenM1 = CNT_W'({optCount, 3'b111});
      PH_DUMMY: lenM1 = CNT_W'(dummyM1);
      default:  lenM1 = CNT_W'(31);
    endcase
  end

  // Burst length clipped at the end of the buffer line
  assign room16    = 16'(BUF_WORDS) - 16'(reqIdx);
  assign burst16   = burstEn ? (16'(burstM1) + 16'd1) : 16'd1;
  assign fillWords = WL_W'((burst16 < room16) ? burst16 : room16);

  assign accept     = (ph == PH_IDLE) && busReq && !manualMode && !busReady;
  assign headEnd    = half && (ph != PH_IDLE) && (ph != PH_DATA) && (bitCnt == lenM1);
  assign dataBitEnd = half && (ph == PH_DATA);

  always_comb begin
    strb           = '0;
    strb.startFill = accept && !hit;
    strb.respHit   = accept && hit;
    strb.loadTx    = (accept && !hit) || headEnd;
    strb.loadPhase = nextPh;
    strb.shiftTx   = half && (ph != PH_IDLE) && (ph != PH_DATA);
    strb.shiftRx   = dataBitEnd;
    strb.storeWord = dataBitEnd && (bitCnt == CNT_W'(31));
    strb.respFill  = dataBitEnd && (bitCnt == CNT_W'(31)) && firstWord;
  end

  assign flashCsN  = (ph == PH_IDLE);
  assign flashSclk = half;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph        <= PH_IDLE;
      half      <= 1'b0;
      bitCnt    <= '0;
      wordsLeft <= '0;
      firstWord <= 1'b0;
      busReady  <= 1'b0;
    end else begin
      busReady <= 1'b0;
      if (ph == PH_IDLE) begin
        if (accept) begin
          if (hit) begin
            busReady <= 1'b1;
          end else begin
            ph        <= nextPh;
            half      <= 1'b0;
            bitCnt    <= '0;
            wordsLeft <= fillWords;
            firstWord <= 1'b1;
          end
        end
      end else if (!half) begin
        half <= 1'b1;
      end else begin
        half <= 1'b0;
        if (ph == PH_DATA) begin
          if (bitCnt == CNT_W'(31)) begin
            bitCnt    <= '0;
            firstWord <= 1'b0;
            if (firstWord) busReady <= 1'b1;
            wordsLeft <= wordsLeft - 1'b1;
            if (wordsLeft == WL_W'(1)) ph <= PH_IDLE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else if (bitCnt == lenM1) begin
          ph     <= nextPh;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/flash_read_window.sv
module flash_read_window
  import flashwin_pkg::*;
#(
  parameter int OFS_W     = 26,
  parameter int EXT_W     = 4,
  parameter int BUF_WORDS = 32,
  parameter int BURST_W   = 5,
  parameter int DUMMY_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReq,
  input  logic [OFS_W-3:0]   busWordAddr,
  output logic               busReady,
  output logic [31:0]        busRdata,
  input  logic               manualMode,
  input  logic [EXT_W-1:0]   extAddr,
  input  logic [2:0]         addrMode,
  input  logic               cmdEn,
  input  logic [7:0]         cmdByte,
  input  logic               addrEn,
  input  logic               optEn,
  input  logic [1:0]         optCount,
  input  logic [31:0]        optBytes,
  input  logic               dummyEn,
  input  logic [DUMMY_W-1:0] dummyM1,
  input  logic               burstEn,
  input  logic [BURST_W-1:0] burstM1,
  input  logic               flush,
  output logic               flashCsN,
  output logic               flashSclk,
  output logic               flashMosi,
  input  logic               flashMiso
);

  localparam int IDX_W = $clog2(BUF_WORDS);

  winStrobes_t      strb;
  logic             hit;
  logic [IDX_W-1:0] reqIdx;

  flashwin_ctrl #(
    .BUF_WORDS(BUF_WORDS),
    .BURST_W  (BURST_W),
    .DUMMY_W  (DUMMY_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busReq    (busReq),
    .manualMode(manualMode),
    .hit       (hit),
    .reqIdx    (reqIdx),
    .cmdEn     (cmdEn),
    .addrEn    (addrEn),
    .optEn     (optEn),
    .dummyEn   (dummyEn),
    .addrMode  (addrMode),
    .optCount  (optCount),
    .dummyM1   (dummyM1),
    .burstEn   (burstEn),
    .burstM1   (burstM1),
    .strb      (strb),
    .busReady  (busReady),
    .flashCsN  (flashCsN),
    .flashSclk (flashSclk)
  );

  flashwin_datapath #(
    .OFS_W    (OFS_W),
    .EXT_W    (EXT_W),
    .BUF_WORDS(BUF_WORDS)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .busWordAddr(busWordAddr),
    .extAddr    (extAddr),
    .addrMode   (addrMode),
    .cmdByte    (cmdByte),
    .optBytes   (optBytes),
    .flush      (flush),
    .flashMiso  (flashMiso),
    .strb       (strb),
    .hit        (hit),
    .reqIdx     (reqIdx),
    .flashMosi  (flashMosi),
    .busRdata   (busRdata)
  );

endmodule

// File: rtl/flash_read_window_chk.sv
module flash_read_window_chk (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic busReady,
  input logic manualMode,
  input logic flashCsN,
  input logic flashSclk,
  input logic flashMosi
);

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    flashCsN |-> !flashSclk) else $error("serial clock high while deselected"); // R3

  AST_MOSI_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashSclk) |-> $stable(flashMosi)) else $error("mosi moved at rising sclk"); // R3

  AST_MANUAL_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (flashCsN && manualMode) |=> flashCsN) else $error("frame started in manual mode"); // R2

  AST_MANUAL_NO_READY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(manualMode) && $past(flashCsN)) |-> !busReady) else $error("ready in manual mode"); // R2

  AST_READY_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady) else $error("ready longer than one clock"); // R12

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> $past(busReq)) else $error("ready without request"); // R12

endmodule

bind flash_read_window flash_read_window_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busReq    (busReq),
  .busReady  (busReady),
  .manualMode(manualMode),
  .flashCsN  (flashCsN),
  .flashSclk (flashSclk),
  .flashMosi (flashMosi)
);

// File: tb/test_flash_read_window.sv
module test_flash_read_window;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic [23:0] busWordAddr = '0;
  logic        busReady;
  logic [31:0] busRdata;
  logic        manualMode = 1'b0;
  logic [3:0]  extAddr = 4'h0;
  logic [2:0]  addrMode = 3'd0;
  logic        cmdEn = 1'b1;
  logic [7:0]  cmdByte = 8'h0B;
  logic        addrEn = 1'b1;
  logic        optEn = 1'b0;
  logic [1:0]  optCount = 2'd0;
  logic [31:0] optBytes = 32'h0;
  logic        dummyEn = 1'b1;
  logic [4:0]  dummyM1 = 5'd7;
  logic        burstEn = 1'b1;
  logic [4:0]  burstM1 = 5'd7;
  logic        flush = 1'b0;
  logic        flashCsN;
  logic        flashSclk;
  logic        flashMosi;
  logic        flashMiso = 1'b0;

  flash_read_window i_flash_read_window (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWordAddr(busWordAddr),
    .busReady(busReady), .busRdata(busRdata), .manualMode(manualMode),
    .extAddr(extAddr), .addrMode(addrMode), .cmdEn(cmdEn), .cmdByte(cmdByte),
    .addrEn(addrEn), .optEn(optEn), .optCount(optCount), .optBytes(optBytes),
    .dummyEn(dummyEn), .dummyM1(dummyM1), .burstEn(burstEn), .burstM1(burstM1),
    .flush(flush), .flashCsN(flashCsN), .flashSclk(flashSclk),
    .flashMosi(flashMosi), .flashMiso(flashMiso)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] flashWord(input logic [29:0] a);
    return ({2'b00, a} * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  // ---------------- flash model ----------------
  logic [25:0]  curOff = '0;
  logic [29:0]  startAddr = '0;
  logic [127:0] hdrExp, hdrCap;
  int           hdrLen = 0;
  int           bitCount = 0;
  int           dataIdx = 0;
  int           txCount = 0;
  int           expWords = 0;
  string        hdrReq = "R3";

  function automatic void pushBit(input logic b);
    hdrExp = {hdrExp[126:0], b};
    hdrLen++;
  endfunction

  function automatic void buildHeader();
    logic [31:0] a32;
    hdrExp = '0;
    hdrLen = 0;
    startAddr = {extAddr, curOff[25:2], 2'b00};
    a32 = {2'b00, startAddr};
    if (cmdEn) for (int i = 7; i >= 0; i--) pushBit(cmdByte[i]);
    if (addrEn) for (int i = ((addrMode == 3'd1) ? 31 : 23); i >= 0; i--) pushBit(a32[i]);
    if (optEn) for (int i = 31; i >= 32 - 8 * (int'(optCount) + 1); i--) pushBit(optBytes[i]);
    if (dummyEn) for (int i = 0; i <= int'(dummyM1); i++) pushBit(1'b0);
  endfunction

  function automatic logic dataBit(input int i);
    logic [31:0] w;
    w = flashWord(startAddr + 30'(4 * (i / 32)));
    return w[31 - (i % 32)];
  endfunction

  always @(negedge flashCsN) begin
    txCount++;
    bitCount = 0;
    hdrCap = '0;
    buildHeader();
    dataIdx = 0;
    if (hdrLen == 0) begin
      flashMiso = dataBit(0);
      dataIdx = 1;
    end
  end

  always @(posedge flashSclk) begin
    hdrCap = {hdrCap[126:0], flashMosi};
    bitCount++;
    if (bitCount == hdrLen)
      check(hdrCap == hdrExp, hdrReq, "frame header bits", hdrCap[63:0], hdrExp[63:0]);
  end

  always @(negedge flashSclk) begin
    if (bitCount >= hdrLen) begin
      flashMiso = dataBit(dataIdx);
      dataIdx++;
    end
  end

  always @(posedge flashCsN) begin
    if (txCount > 0)
      check((bitCount - hdrLen) == 32 * expWords, "R8", "data bits in frame",
            bitCount - hdrLen, 32 * expWords);
  end

  // ---------------- scoreboard ----------------
  logic [31:0] expQ[$];
  string       monReq = "R12";

  always @(negedge clk) begin
    if (rstN && busReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12", "ready with no pending request", 1, 0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(busRdata == e, monReq, "read data", busRdata, e);
      end
    end
  end

  // bench-side buffer model
  logic [22:0] bTag = '0;
  logic [31:0] bValid = '0;

  task automatic readWord(input logic [25:0] off, input string req);
    logic [22:0] tag;
    int          idx;
    bit          expHit;
    int          tx0;
    int          waitN;
    int          bw;
    tag    = {extAddr, off[25:7]};
    idx    = int'(off[6:2]);
    expHit = (tag == bTag) && bValid[idx];
    tx0    = txCount;
    waitN  = 0;
    if (!expHit) begin
      bw = burstEn ? int'(burstM1) + 1 : 1;
      expWords = (bw < 32 - idx) ? bw : 32 - idx;
      if (tag != bTag) bValid = '0;
      bTag = tag;
      for (int k = 0; k < expWords; k++) bValid[idx + k] = 1'b1;
    end
    curOff = off;
    monReq = req;
    expQ.push_back(flashWord({extAddr, off[25:2], 2'b00}));
    @(negedge clk);
    busWordAddr = off[25:2];
    busReq = 1'b1;
    do begin
      @(negedge clk);
      waitN++;
    end while (!busReady && waitN < 5000);
    busReq = 1'b0;
    if (expHit) check(waitN == 1, req, "hit latency in clocks", waitN, 1);
    while (!flashCsN) @(negedge clk);
    @(negedge clk);
    check((txCount - tx0) == (expHit ? 0 : 1), req, "flash frames", txCount - tx0,
          expHit ? 0 : 1);
  endtask

  task automatic pulseFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    bValid = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int  tx0;
    bit  readySeen;
    bit  csSeen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(flashCsN == 1'b1, "R1", "csN in reset", flashCsN, 1);
    check(flashSclk == 1'b0, "R1", "sclk in reset", flashSclk, 0);
    check(busReady == 1'b0, "R1", "ready in reset", busReady, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    hdrReq = "R3 R6 header";
    readWord(26'h0000100, "R8 miss burst");
    readWord(26'h0000104, "R9 hit");
    readWord(26'h000011C, "R9 hit burst end");
    readWord(26'h0000120, "R8 same-line miss");
    readWord(26'h0000108, "R11 earlier words kept");
    readWord(26'h0000178, "R8 clipped burst");
    readWord(26'h000017C, "R9 hit in clipped burst");
    pulseFlush();
    readWord(26'h0000104, "R10 refetch after flush");
    readWord(26'h0002000, "R11 new line");
    readWord(26'h0000104, "R11 old line discarded");

    // R4 R5: 32-bit address, extended nibble, option bytes
    extAddr = 4'hA; addrMode = 3'd1; optEn = 1'b1; optCount = 2'd1;
    optBytes = 32'hC35A_9911; cmdByte = 8'h0C;
    pulseFlush();
    hdrReq = "R4 R5 header";
    readWord(26'h3FFFFF0, "R4 top of window");
    readWord(26'h3FFFFF4, "R4 hit");
    extAddr = 4'h3;
    readWord(26'h3FFFFF4, "R4 extended address in tag");

    // R7: command and dummy left out, single word fetch
    extAddr = 4'h0; addrMode = 3'd0; optEn = 1'b0; cmdEn = 1'b0; dummyEn = 1'b0;
    burstEn = 1'b0;
    pulseFlush();
    hdrReq = "R7 header";
    readWord(26'h0000040, "R7 R8 single word");
    readWord(26'h0000044, "R8 burst disabled");
    addrEn = 1'b0;
    readWord(26'h0000080, "R7 data phase only");

    // R2 manual mode
    addrEn = 1'b1; cmdEn = 1'b1; dummyEn = 1'b1; burstEn = 1'b1;
    manualMode = 1'b1;
    tx0 = txCount;
    readySeen = 1'b0;
    csSeen = 1'b0;
    @(negedge clk);
    busWordAddr = 24'h000300;
    busReq = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (busReady) readySeen = 1'b1;
      if (!flashCsN) csSeen = 1'b1;
    end
    busReq = 1'b0;
    @(negedge clk);
    manualMode = 1'b0;
    check(!readySeen, "R2", "ready while manual", readySeen, 0);
    check(!csSeen && txCount == tx0, "R2", "frames while manual", txCount - tx0, 0);
    readWord(26'h0000C00, "R2 window after manual cleared");

    check(expQ.size() == 0, "R12", "pending responses", expQ.size(), 0);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule